// File: doc/BRIEF.md
# Frame Buffer DMA Address Reload Unit

This block holds the frame-buffer addresses for the fetch side of a display controller. It drives one fetch channel in single-panel mode and two in dual-panel mode. Each channel has a base register that software writes and a current pointer that gives the address of the next fetch. The pointer moves forward one word for each fetch the memory side accepts. When the pointer reaches the last word of the frame, the base is copied back into it. The end of the frame is computed from the address where the frame started and a programmable frame length.

A read-only update flag supports double buffering. It rises once the hardware has taken the current base, so software knows it may program the next buffer. In dual-panel mode the flag waits until both channels have reloaded. Software clears it by writing the second channel's base, so the first channel must be programmed first. The block also passes fetched read data through. A read that returns a bus error is replaced by zero data and marked with a one-cycle error strobe. Fetching does not stop on an error.

Top module: `fbAddrReload`

## Requirements
- R1: When `enable` goes from 0 to 1, the base of channel 0 is copied into its pointer and into its frame start. Channel 1 is loaded the same way when `dualMode` is 1. The new pointer is visible one cycle later.
- R2: While enabled, an accepted fetch (`fetchAck[ch]`=1) on an active channel whose pointer is not at the frame end moves the pointer up by WORD_BYTES.
- R3: The frame end is frame start + `frameBytes` − WORD_BYTES. An accepted fetch at the frame end copies the channel's base into its pointer and its frame start.
- R4: A base write in the same cycle as a reload does not affect that reload, which uses the previous base. The new value is used at the next reload.
- R5: With `dualMode`=0, `updateFlag` rises with the channel 0 reload and is cleared by a write to base 0. A write to base 1 leaves it unchanged.
- R6: With `dualMode`=1, `updateFlag` is 1 only once both channels have reloaded since the last clear. A write to base 1 clears the flag and both reload marks. A write to base 0 does not clear it.
- R7: If a clearing base write and a reload happen in the same cycle, the clear wins and `updateFlag` reads 0 afterwards.
- R8: One cycle after `rdValid`, `dataOutValid` is 1. `dataOut` carries `rdData` when `rdErr` was 0 and all zeros when `rdErr` was 1.
- R9: `busErr` is 1 for exactly the cycle after each read beat that has `rdErr`=1, and 0 otherwise.
- R10: While `enable` is 0, or for channel 1 while `dualMode` is 0, fetch acknowledges are ignored and the pointer holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Controller enable; a rising edge loads the pointers |
| dualMode | input | 1 | 1 makes channel 1 active |
| frameBytes | input | SIZE_W | Frame length in bytes per channel |
| baseWrEn | input | 2 | Per-channel base register write strobe |
| baseWrData | input | ADDR_W | Base address write value |
| fetchAck | input | 2 | Per-channel fetch accepted |
| fetchAddr | output | 2×ADDR_W | Current pointer per channel |
| rdValid | input | 1 | Read data beat present |
| rdErr | input | 1 | Read beat returned a bus error |
| rdData | input | DATA_W | Read data |
| dataOut | output | DATA_W | Fetched data, zeroed on error |
| dataOutValid | output | 1 | `dataOut` valid |
| busErr | output | 1 | One-cycle bus error strobe |
| updateFlag | output | 1 | Base taken; a new base may be written |

## Verification
The bench checks the wrap point. A design that compares the pointer against the wrong end would run one word past the frame or reload one word early, and `fetchAddr` would then differ from the model at the wrap. It writes a base in the same cycle as a reload. A design that let the write pass through would jump straight to the new buffer, and one where the reload beat the clear would leave `updateFlag` set. In dual mode it writes only base 0 and completes only one channel's reload, and a flag that did not wait for both would rise early. It also sends bus errors back to back, mixed with clean beats, to catch stale data leaking through or a strobe that is stretched or dropped.

// File: rtl/fbReloadPkg.sv
package fbReloadPkg;
  localparam int CH = 2;

  typedef struct packed {
    logic [CH-1:0] load;   // copy base into pointer and frame start
    logic [CH-1:0] step;   // advance pointer by one word
  } ctlStrobe_t;
endpackage

// File: rtl/fbReloadCtl.sv
module fbReloadCtl
  import fbReloadPkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                dualMode,
  input  logic [CH-1:0]       fetchAck,
  input  logic [CH-1:0]       baseWrEn,
  input  logic [CH-1:0]       atEnd,
  output ctlStrobe_t          ctl,
  output logic                updateFlag
);
  logic          enDly;
  logic          enRise;
  logic [CH-1:0] chActive;
  logic [CH-1:0] reloaded;
  logic          flagClear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enDly <= 1'b0;
    else       enDly <= enable;
  end

  assign enRise = enable & ~enDly;

  always_comb begin
    for (int c = 0; c < CH; c++) begin
      chActive[c]  = (c == 0) ? 1'b1 : dualMode;
      ctl.load[c]  = chActive[c] & (enRise | (enable & fetchAck[c] & atEnd[c]));
      ctl.step[c]  = chActive[c] & enable & ~enRise & fetchAck[c] & ~atEnd[c];
    end
  end

  // the clearing write belongs to the last channel that software programs
  assign flagClear = dualMode ? baseWrEn[CH-1] : baseWrEn[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          reloaded <= '0;
    else if (flagClear) reloaded <= '0;
    else                reloaded <= reloaded | ctl.load;
  end

  assign updateFlag = dualMode ? (&reloaded) : reloaded[0];
endmodule

// File: rtl/fbReloadPath.sv
module fbReloadPath
  import fbReloadPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 16,
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctlStrobe_t                   ctl,
  input  logic [CH-1:0]                baseWrEn,
  input  logic [ADDR_W-1:0]            baseWrData,
  input  logic [SIZE_W-1:0]            frameBytes,
  input  logic                         rdValid,
  input  logic                         rdErr,
  input  logic [DATA_W-1:0]            rdData,
  output logic [CH-1:0][ADDR_W-1:0]    fetchAddr,
  output logic [CH-1:0][ADDR_W-1:0]    baseVal,
  output logic [CH-1:0][ADDR_W-1:0]    endAddr,
  output logic [CH-1:0]                atEnd,
  output logic [DATA_W-1:0]            dataOut,
  output logic                         dataOutValid,
  output logic                         busErr
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

  for (genvar c = 0; c < CH; c++) begin : gChan
    logic [ADDR_W-1:0] baseQ, curQ, startQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        baseQ  <= '0;
        curQ   <= '0;
        startQ <= '0;
      end else begin
        if (baseWrEn[c]) baseQ <= baseWrData;
        if (ctl.load[c]) begin
          curQ   <= baseQ;
          startQ <= baseQ;
        end else if (ctl.step[c]) begin
          curQ <= curQ + STEP;
        end
      end
    end

    assign endAddr[c]   = startQ + ADDR_W'(frameBytes) - STEP;
    assign atEnd[c]     = (curQ == endAddr[c]);
    assign fetchAddr[c] = curQ;
    assign baseVal[c]   = baseQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut      <= '0;
      dataOutValid <= 1'b0;
      busErr       <= 1'b0;
    end else begin
      dataOutValid <= rdValid;
      busErr       <= rdValid & rdErr;
      dataOut      <= (rdValid && !rdErr) ? rdData : '0;
    end
  end
endmodule

// File: rtl/fbAddrReload.sv
module fbAddrReload
  import fbReloadPkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SIZE_W     = 16,
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         enable,
  input  logic                         dualMode,
  input  logic [SIZE_W-1:0]            frameBytes,
  input  logic [1:0]                   baseWrEn,
  input  logic [ADDR_W-1:0]            baseWrData,
  input  logic [1:0]                   fetchAck,
  output logic [1:0][ADDR_W-1:0]       fetchAddr,
  input  logic                         rdValid,
  input  logic                         rdErr,
  input  logic [DATA_W-1:0]            rdData,
  output logic [DATA_W-1:0]            dataOut,
  output logic                         dataOutValid,
  output logic                         busErr,
  output logic                         updateFlag
);
  ctlStrobe_t                ctl;
  logic [CH-1:0]             atEnd;
  logic [CH-1:0][ADDR_W-1:0] baseVal;
  logic [CH-1:0][ADDR_W-1:0] endAddr;

  fbReloadCtl uCtl (
    .clk(clk), .rstN(rstN), .enable(enable), .dualMode(dualMode),
    .fetchAck(fetchAck), .baseWrEn(baseWrEn), .atEnd(atEnd),
    .ctl(ctl), .updateFlag(updateFlag)
  );

  fbReloadPath #(
    .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)
  ) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .baseWrEn(baseWrEn),
    .baseWrData(baseWrData), .frameBytes(frameBytes),
    .rdValid(rdValid), .rdErr(rdErr), .rdData(rdData),
    .fetchAddr(fetchAddr), .baseVal(baseVal), .endAddr(endAddr), .atEnd(atEnd),
    .dataOut(dataOut), .dataOutValid(dataOutValid), .busErr(busErr)
  );
endmodule

// File: rtl/fbAddrReloadChk.sv
module fbAddrReloadChk #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   enable,
  input logic                   dualMode,
  input logic [1:0]             baseWrEn,
  input logic [1:0]             fetchAck,
  input logic [1:0][ADDR_W-1:0] fetchAddr,
  input logic [1:0][ADDR_W-1:0] baseVal,
  input logic [1:0][ADDR_W-1:0] endAddr,
  input logic                   rdValid,
  input logic                   rdErr,
  input logic [DATA_W-1:0]      dataOut,
  input logic                   dataOutValid,
  input logic                   busErr,
  input logic                   updateFlag
);
  a_r1_enable_load: assert property (@(posedge clk) disable iff (!rstN)
    $rose(enable) |=> fetchAddr[0] == $past(baseVal[0]));

  a_r2_step: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && fetchAck[0] && fetchAddr[0] != endAddr[0])
      |=> fetchAddr[0] == $past(fetchAddr[0]) + ADDR_W'(WORD_BYTES));

  a_r3_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (enable && fetchAck[0] && fetchAddr[0] == endAddr[0])
      |=> fetchAddr[0] == $past(baseVal[0]));

  a_r5_single_clear: assert property (@(posedge clk) disable iff (!rstN)
    (!dualMode && baseWrEn[0]) |=> !updateFlag);

  a_r6_dual_clear: assert property (@(posedge clk) disable iff (!rstN)
    (dualMode && baseWrEn[1]) |=> !updateFlag);

  a_r8_zero_fill: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdErr) |=> (dataOutValid && dataOut == '0 && busErr));

  a_r9_strobe_src: assert property (@(posedge clk) disable iff (!rstN)
    busErr |-> $past(rdValid && rdErr));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> $stable(fetchAddr));
endmodule

bind fbAddrReload fbAddrReloadChk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_BYTES(WORD_BYTES)
) uChk (
  .clk(clk), .rstN(rstN), .enable(enable), .dualMode(dualMode),
  .baseWrEn(baseWrEn), .fetchAck(fetchAck), .fetchAddr(fetchAddr),
  .baseVal(baseVal), .endAddr(endAddr), .rdValid(rdValid), .rdErr(rdErr),
  .dataOut(dataOut), .dataOutValid(dataOutValid), .busErr(busErr),
  .updateFlag(updateFlag)
);

// File: tb/tb_fbAddrReload.sv
`timescale 1ns/1ps
module tb_fbAddrReload;
  localparam int AW = 32, SW = 16, DW = 32, WB = 4;

  logic clk = 1'b0, rstN = 1'b0;
  logic enable = 0, dualMode = 0;
  logic [SW-1:0] frameBytes = 16'd16;
  logic [1:0] baseWrEn = 0, fetchAck = 0;
  logic [AW-1:0] baseWrData = 0;
  logic rdValid = 0, rdErr = 0;
  logic [DW-1:0] rdData = 0;
  logic [1:0][AW-1:0] fetchAddr;
  logic [DW-1:0] dataOut;
  logic dataOutValid, busErr, updateFlag;

  int nRun = 0, nFail = 0;
  bit finished = 0;

  // reference state
  logic [AW-1:0] mBase [2], mCur [2], mStart [2];
  logic [1:0] mDone;
  logic mEnPrev, mFlag, mValid, mErr;
  logic [DW-1:0] mData;

  always #4 clk = ~clk;

  fbAddrReload #(.ADDR_W(AW), .SIZE_W(SW), .DATA_W(DW), .WORD_BYTES(WB)) dut (
    .clk(clk), .rstN(rstN), .enable(enable), .dualMode(dualMode),
    .frameBytes(frameBytes), .baseWrEn(baseWrEn), .baseWrData(baseWrData),
    .fetchAck(fetchAck), .fetchAddr(fetchAddr), .rdValid(rdValid),
    .rdErr(rdErr), .rdData(rdData), .dataOut(dataOut),
    .dataOutValid(dataOutValid), .busErr(busErr), .updateFlag(updateFlag)
  );

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] frameEnd(int c);
    return mStart[c] + AW'(frameBytes) - AW'(WB);
  endfunction

  // one clock: advance the reference from the applied inputs, then compare
  task automatic tick();
    logic [1:0] ld, st;
    logic enRise, clr;
    string tagA [2];
    enRise = enable && !mEnPrev;
    for (int c = 0; c < 2; c++) begin
      logic act;
      act   = (c == 0) || dualMode;
      ld[c] = act && (enRise || (enable && fetchAck[c] && mCur[c] == frameEnd(c)));
      st[c] = act && enable && !enRise && fetchAck[c] && mCur[c] != frameEnd(c);
      tagA[c] = ld[c] ? (enRise ? "R1" : "R3") : (st[c] ? "R2" : "R10");
    end
    for (int c = 0; c < 2; c++) begin
      if (ld[c]) begin mCur[c] = mBase[c]; mStart[c] = mBase[c]; end
      else if (st[c]) mCur[c] = mCur[c] + AW'(WB);
      if (baseWrEn[c]) mBase[c] = baseWrData;
    end
    clr = dualMode ? baseWrEn[1] : baseWrEn[0];
    mDone = clr ? 2'b00 : (mDone | ld);
    mFlag = dualMode ? (&mDone) : mDone[0];
    mEnPrev = enable;
    mValid = rdValid;
    mErr = rdValid && rdErr;
    mData = (rdValid && !rdErr) ? rdData : '0;
    @(posedge clk);
    @(negedge clk);
    check({tagA[0], " ch0 addr"}, 64'(fetchAddr[0]), 64'(mCur[0]));
    check({tagA[1], " ch1 addr"}, 64'(fetchAddr[1]), 64'(mCur[1]));
    check(dualMode ? "R6 flag" : "R5 flag", 64'(updateFlag), 64'(mFlag));
    check("R8 valid", 64'(dataOutValid), 64'(mValid));
    check("R8 data", 64'(dataOut), 64'(mData));
    check("R9 strobe", 64'(busErr), 64'(mErr));
  endtask

  task automatic idle();
    baseWrEn = 0; fetchAck = 0; rdValid = 0; rdErr = 0;
  endtask

  task automatic writeBase(int c, logic [AW-1:0] v);
    idle(); baseWrEn[c] = 1'b1; baseWrData = v; tick(); idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    for (int c = 0; c < 2; c++) begin mBase[c] = 0; mCur[c] = 0; mStart[c] = 0; end
    mDone = 0; mEnPrev = 0; mFlag = 0; mValid = 0; mErr = 0; mData = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset addr", 64'(fetchAddr[0]), 64'h0);
    check("R5 reset flag", 64'(updateFlag), 64'h0);
    check("R9 reset strobe", 64'(busErr), 64'h0);

    // R1/R3/R4/R7 directed, single mode, 2-word frame
    frameBytes = 16'd8;
    writeBase(0, 32'h1000);
    enable = 1; tick();
    check("R1 load base", 64'(fetchAddr[0]), 64'h1000);
    check("R5 flag after load", 64'(updateFlag), 64'h1);
    writeBase(0, 32'h2000);
    check("R5 clear by base0 write", 64'(updateFlag), 64'h0);
    fetchAck[0] = 1; tick();
    check("R2 step", 64'(fetchAddr[0]), 64'h1004);
    baseWrEn[0] = 1; baseWrData = 32'h3000; tick(); idle();
    check("R4 reload uses older base", 64'(fetchAddr[0]), 64'h2000);
    check("R7 clear wins over reload", 64'(updateFlag), 64'h0);
    fetchAck[0] = 1; tick(); tick(); idle();
    check("R4 new base at next reload", 64'(fetchAddr[0]), 64'h3000);
    writeBase(1, 32'h7000);
    check("R5 base1 write ignored for flag", 64'(updateFlag), 64'h1);
    fetchAck[1] = 1; tick(); idle();
    check("R10 ch1 ack ignored single", 64'(fetchAddr[1]), 64'h0);

    // R6 dual mode
    enable = 0; tick(); dualMode = 1;
    writeBase(0, 32'h4000); writeBase(1, 32'h8000);
    enable = 1; tick();
    check("R6 flag both loaded", 64'(updateFlag), 64'h1);
    writeBase(0, 32'h4100);
    check("R6 base0 write no clear", 64'(updateFlag), 64'h1);
    writeBase(1, 32'h8100);
    check("R6 base1 write clears", 64'(updateFlag), 64'h0);
    fetchAck = 2'b01; tick(); tick(); idle();
    check("R6 one channel not enough", 64'(updateFlag), 64'h0);
    fetchAck = 2'b10; tick(); tick(); idle();
    check("R6 both reloaded", 64'(updateFlag), 64'h1);
    check("R3 ch1 wrap", 64'(fetchAddr[1]), 64'h8100);

    // R8/R9 back-to-back errors
    rdValid = 1; rdErr = 1; rdData = 32'hDEAD_BEEF; tick();
    check("R8 zero on error", 64'(dataOut), 64'h0);
    tick(); rdErr = 0; rdData = 32'h1234_5678; tick(); idle(); tick();
    check("R9 strobe drops", 64'(busErr), 64'h0);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      idle();
      if ($urandom_range(0, 199) == 0) begin
        enable = ~enable;
        if (!enable) begin
          dualMode = $urandom_range(0, 1);
          frameBytes = SW'(WB * $urandom_range(1, 5));
        end
      end
      if ($urandom_range(0, 15) == 0) begin
        baseWrEn[$urandom_range(0, 1)] = 1'b1;
        baseWrData = {$urandom_range(0, 32'h3FFF_FFFF), 2'b00};
      end
      fetchAck = 2'($urandom_range(0, 3));
      rdValid = $urandom_range(0, 1);
      rdErr = ($urandom_range(0, 3) == 0);
      rdData = $urandom;
      tick();
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule